// File: doc/BRIEF.md
# Invalidation queue descriptor processor

This block is the hardware consumer of an invalidation queue that software keeps in memory for a DMA remapping unit. Software programs the ring's base address, turns the queue on through the global command register and then advances a tail offset after placing 16-byte descriptors in the ring. The block fetches each descriptor from its head position as two 64-bit reads, the low word first. It then classifies the descriptor by its type code and carries out the matching action. The head advances by one slot only when that action has finished.

There are two kinds of action. Cache-invalidation descriptors (context cache, IOTLB, device IOTLB and interrupt entry cache) go out on a request/acknowledge port, with the type code and both words attached. The translation caches themselves sit outside the block. A wait descriptor can ask for a 32-bit status word to be written to a memory address, which software polls to learn that everything queued before it has completed. Any unrecognised type code parks the engine on that slot and raises a fault flag. Software clears the flag after it repairs the ring.

Top module: `inv_queue_engine`

## Requirements
- R1: After reset the head, tail, base and completion status registers read zero, the global status enable bit (bit 26) reads zero, and neither the memory port nor the invalidation port requests anything.
- R2: The capability register at offset 0x10 reads bit 1 set when queue support is configured in, and all other bits zero.
- R3: Writing bit 26 of the command register (offset 0x18) enables the queue, and bit 26 of the global status register (offset 0x1C) reads 1 from the following cycle. Clearing it disables the queue, forces the head to zero and clears the status bit.
- R4: While the queue is disabled, tail writes (offset 0x88) are stored and read back, but no memory access is issued.
- R5: Descriptor at slot i is fetched as a read of base+16*i (low word) followed by a read of base+16*i+8 (high word). Base is at offset 0x90. Each memory request holds its address until acknowledged.
- R6: A descriptor whose low-word bits 3:0 are 1, 2, 3 or 4 raises inv_req, with inv_kind equal to that code and both words unchanged, until inv_ack. The head (offset 0x80, read as 16 times the slot index) advances by one slot only after the acknowledge.
- R7: A wait descriptor (code 5) with low-word bit 5 set writes low-word bits 63:32 as 32-bit data to the address in the high word. The head advances after the write is acknowledged, and bit 0 of the completion status register (offset 0x98) is set.
- R8: A wait descriptor with low-word bit 5 clear issues no memory write, advances the head and sets completion status bit 0.
- R9: A descriptor with any other code in bits 3:0 (0 or 6 to 15) sets completion status bit 1 and leaves the head on that slot. No further fetch or request is issued until software clears bit 1, after which the same slot is fetched again.
- R10: Completion status bits are cleared by writing 1 to them, writing 0 leaves them unchanged, and a set event in the same cycle wins.
- R11: Fetching stops when the head equals the tail. The head and tail indices wrap from the last slot of the ring to slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a 32-bit status write, 0 for a 64-bit read |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Status write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| inv_req | output | 1 | Cache invalidation request, held until inv_ack |
| inv_kind | output | 4 | Descriptor type code (1 to 4) |
| inv_lo | output | 64 | Descriptor low word |
| inv_hi | output | 64 | Descriptor high word |
| inv_ack | input | 1 | Invalidation done acknowledge |

## Verification
The hardest situation to reach from the ports is a fault parked on one slot while later descriptors are already queued behind it. In that state the engine must stay silent, keep the head on the faulting slot, and then fetch the same slot again once it is repaired and the flag is cleared. The bench reaches this state for every unused type code in turn by planting the bad code and ringing the tail. It then rewrites that slot in its memory model before clearing the flag. A second hard case is the window between an invalidation request and its acknowledge. The bench stretches this window with a long acknowledge delay and reads the head while the request is still held.

// File: rtl/iq_pkg.sv
// Shared constants and types for the invalidation queue engine.
// Assumes 64-bit register access and 64-bit memory addressing.
package iq_pkg;
    localparam int MEM_AW = 64;
    localparam int REG_W  = 64;

    // Register byte offsets
    localparam logic [7:0] OFS_CAP   = 8'h10;
    localparam logic [7:0] OFS_CMD   = 8'h18;
    localparam logic [7:0] OFS_GSTAT = 8'h1C;
    localparam logic [7:0] OFS_HEAD  = 8'h80;
    localparam logic [7:0] OFS_TAIL  = 8'h88;
    localparam logic [7:0] OFS_BASE  = 8'h90;
    localparam logic [7:0] OFS_CPL   = 8'h98;

    localparam int EN_BIT      = 26;
    localparam int CAP_QI_BIT  = 1;
    localparam int WAIT_WR_BIT = 5;
    localparam int CPL_DONE    = 0;
    localparam int CPL_FAULT   = 1;

    // Descriptor type codes
    localparam logic [3:0] CODE_CTX    = 4'd1;
    localparam logic [3:0] CODE_IOTLB  = 4'd2;
    localparam logic [3:0] CODE_DEVTLB = 4'd3;
    localparam logic [3:0] CODE_IREC   = 4'd4;
    localparam logic [3:0] CODE_WAIT   = 4'd5;

    typedef enum logic [1:0] {
        CL_BAD  = 2'd0,
        CL_INV  = 2'd1,
        CL_WAIT = 2'd2
    } desc_class_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_LO  = 3'd1,
        ST_RD_HI  = 3'd2,
        ST_DECODE = 3'd3,
        ST_INV    = 3'd4,
        ST_WR     = 3'd5,
        ST_FAULT  = 3'd6
    } eng_state_e;
endpackage

// File: rtl/iq_desc_decode.sv
// Descriptor classifier: splits a fetched low word into its type class,
// the wait write request flag and the 32-bit status data.
// Assumes the type code occupies bits 3:0 of the low word.
module iq_desc_decode
    import iq_pkg::*;
(
    input  logic [63:0]  lo_i,
    output desc_class_e  cls_o,
    output logic         want_wr_o,
    output logic [3:0]   code_o,
    output logic [31:0]  stat_o
);
    assign code_o    = lo_i[3:0];
    assign want_wr_o = lo_i[WAIT_WR_BIT];
    assign stat_o    = lo_i[63:32];

    // Map the type code onto an action class
    always_comb begin
        unique case (lo_i[3:0])
            CODE_CTX, CODE_IOTLB, CODE_DEVTLB, CODE_IREC: cls_o = CL_INV;
            CODE_WAIT:                                    cls_o = CL_WAIT;
            default:                                      cls_o = CL_BAD;
        endcase
    end
endmodule

// File: rtl/iq_csr.sv
// Register file: base, tail, enable and completion flags, plus the read
// mux that also exposes the engine's head and active status.
// Assumes single-cycle writes at 64-bit granularity; reads are combinational.
module iq_csr
    import iq_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter bit QI_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [7:0]        addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [IDX_W-1:0]  head_i,
    input  logic              active_i,
    input  logic              done_set_i,
    input  logic              fault_set_i,
    output logic              en_o,
    output logic [MEM_AW-1:0] base_o,
    output logic [IDX_W-1:0]  tail_o,
    output logic              fault_o
);
    logic              en_q;
    logic [MEM_AW-1:0] base_q;
    logic [IDX_W-1:0]  tail_q;
    logic              done_q;
    logic              fault_q;
    logic              cpl_wr;

    assign cpl_wr = wr_i && (addr_i == OFS_CPL);

    // Software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
            tail_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                OFS_CMD:  en_q   <= wdata_i[EN_BIT] & QI_CAP;
                OFS_TAIL: tail_q <= wdata_i[IDX_W+3:4];
                OFS_BASE: base_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    // Completion flags: set by the engine, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= done_set_i  | (done_q  & ~(cpl_wr & wdata_i[CPL_DONE]));
            fault_q <= fault_set_i | (fault_q & ~(cpl_wr & wdata_i[CPL_FAULT]));
        end
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_CAP:   rdata_o[CAP_QI_BIT] = QI_CAP;
            OFS_CMD:   rdata_o[EN_BIT] = en_q;
            OFS_GSTAT: rdata_o[EN_BIT] = active_i;
            OFS_HEAD:  rdata_o[IDX_W+3:4] = head_i;
            OFS_TAIL:  rdata_o[IDX_W+3:4] = tail_q;
            OFS_BASE:  rdata_o = base_q;
            OFS_CPL: begin
                rdata_o[CPL_DONE]  = done_q;
                rdata_o[CPL_FAULT] = fault_q;
            end
            default:   rdata_o = '0;
        endcase
    end

    assign en_o    = en_q;
    assign base_o  = base_q;
    assign tail_o  = tail_q;
    assign fault_o = fault_q;

    // R9: a fault flag survives until software writes 1 to it
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q && !(cpl_wr && wdata_i[CPL_FAULT]) |=> fault_q);

    // R10: writing 1 clears the done flag unless a new set arrives
    p_done_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_wr && wdata_i[CPL_DONE] && !done_set_i |=> !done_q);
endmodule

// File: rtl/iq_engine.sv
// Fetch/dispatch engine: walks the ring from head to tail, reads each
// descriptor as two 64-bit words, then issues an invalidation request,
// a status write or a fault. The head moves only after completion.
// Assumes the ring depth is a power of two and the base is stable while enabled.
module iq_engine
    import iq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fault_i,
    input  logic [MEM_AW-1:0] base_i,
    input  logic [IDX_W-1:0]  tail_i,
    output logic [IDX_W-1:0]  head_o,
    output logic              active_o,
    output logic              done_set_o,
    output logic              fault_set_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [63:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              inv_req_o,
    output logic [3:0]        inv_kind_o,
    output logic [63:0]       inv_lo_o,
    output logic [63:0]       inv_hi_o,
    input  logic              inv_ack_i
);
    eng_state_e        state_q;
    logic [IDX_W-1:0]  head_q;
    logic              active_q;
    logic [63:0]       lo_q;
    logic [63:0]       hi_q;
    desc_class_e       cls;
    logic              want_wr;
    logic [3:0]        code;
    logic [31:0]       stat;
    logic [MEM_AW-1:0] slot_ofs;
    logic [MEM_AW-1:0] slot_addr;

    iq_desc_decode u_dec (
        .lo_i      (lo_q),
        .cls_o     (cls),
        .want_wr_o (want_wr),
        .code_o    (code),
        .stat_o    (stat)
    );

    // Byte address of the slot under the head
    always_comb begin
        slot_ofs = '0;
        slot_ofs[IDX_W+3:4] = head_q;
        slot_addr = base_i + slot_ofs;
    end

    // Sequencer, head pointer and descriptor capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            head_q   <= '0;
            active_q <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else if (!en_i) begin
            state_q  <= ST_IDLE;
            head_q   <= '0;
            active_q <= 1'b0;
        end else begin
            active_q <= 1'b1;
            unique case (state_q)
                ST_IDLE:   if (!fault_i && head_q != tail_i) state_q <= ST_RD_LO;
                ST_RD_LO:  if (mem_ack_i) begin
                               lo_q    <= mem_rdata_i;
                               state_q <= ST_RD_HI;
                           end
                ST_RD_HI:  if (mem_ack_i) begin
                               hi_q    <= mem_rdata_i;
                               state_q <= ST_DECODE;
                           end
                ST_DECODE: begin
                    if (cls == CL_BAD)           state_q <= ST_FAULT;
                    else if (cls == CL_INV)      state_q <= ST_INV;
                    else if (want_wr)            state_q <= ST_WR;
                    else begin
                        head_q  <= head_q + 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_INV:    if (inv_ack_i) begin
                               head_q  <= head_q + 1'b1;
                               state_q <= ST_IDLE;
                           end
                ST_WR:     if (mem_ack_i) begin
                               head_q  <= head_q + 1'b1;
                               state_q <= ST_IDLE;
                           end
                ST_FAULT:  if (!fault_i) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive
    always_comb begin
        mem_req_o   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI) || (state_q == ST_WR);
        mem_we_o    = (state_q == ST_WR);
        mem_wdata_o = stat;
        unique case (state_q)
            ST_RD_HI: mem_addr_o = slot_addr + 64'd8;
            ST_WR:    mem_addr_o = hi_q;
            default:  mem_addr_o = slot_addr;
        endcase
    end

    // Invalidation port and completion events
    always_comb begin
        inv_req_o   = (state_q == ST_INV);
        inv_kind_o  = code;
        inv_lo_o    = lo_q;
        inv_hi_o    = hi_q;
        done_set_o  = en_i && (((state_q == ST_DECODE) && (cls == CL_WAIT) && !want_wr)
                               || ((state_q == ST_WR) && mem_ack_i));
        fault_set_o = en_i && (state_q == ST_DECODE) && (cls == CL_BAD);
    end

    assign head_o   = head_q;
    assign active_o = active_q;

    // R3: status follows the enable one cycle later
    p_active_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> active_o);

    // R3/R4: a disabled queue is silent with the head at zero
    p_quiet_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!mem_req_o && !inv_req_o && head_q == '0));

    // R5: a memory request keeps its address until acknowledged
    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && mem_req_o && !mem_ack_i |=> !en_i || (mem_req_o && $stable(mem_addr_o)));

    // R6: an invalidation request is held and the head waits for the ack
    p_inv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && inv_req_o && !inv_ack_i |=> !en_i || (inv_req_o && head_q == $past(head_q)));

    // R6: one acknowledged action moves the head by exactly one slot
    p_head_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && inv_req_o && inv_ack_i |=> !en_i || head_q == $past(head_q) + 1'b1);

    // R9: nothing is requested while the fault flag is up
    p_fault_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |-> (!mem_req_o && !inv_req_o));

    // R11: an empty ring starts no fetch
    p_stop_at_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && state_q == ST_IDLE && head_q == tail_i |=> !mem_req_o);

    // Request ports never overlap
    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && inv_req_o));
endmodule

// File: rtl/inv_queue_engine.sv
// Top of the invalidation queue processor: register file plus engine.
// Assumes RING_DEPTH is a power of two of at least 2.
module inv_queue_engine
    import iq_pkg::*;
#(
    parameter int RING_DEPTH = 256,
    parameter bit QI_CAP     = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [63:0] mem_rdata,
    input  logic        mem_ack,
    output logic        inv_req,
    output logic [3:0]  inv_kind,
    output logic [63:0] inv_lo,
    output logic [63:0] inv_hi,
    input  logic        inv_ack
);
    localparam int IDX_W = $clog2(RING_DEPTH);

    logic              en;
    logic              fault;
    logic              active;
    logic              done_set;
    logic              fault_set;
    logic [MEM_AW-1:0] base;
    logic [IDX_W-1:0]  tail;
    logic [IDX_W-1:0]  head;

    iq_csr #(.IDX_W(IDX_W), .QI_CAP(QI_CAP)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .head_i      (head),
        .active_i    (active),
        .done_set_i  (done_set),
        .fault_set_i (fault_set),
        .en_o        (en),
        .base_o      (base),
        .tail_o      (tail),
        .fault_o     (fault)
    );

    iq_engine #(.IDX_W(IDX_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .fault_i     (fault),
        .base_i      (base),
        .tail_i      (tail),
        .head_o      (head),
        .active_o    (active),
        .done_set_o  (done_set),
        .fault_set_o (fault_set),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_ack_i   (mem_ack),
        .inv_req_o   (inv_req),
        .inv_kind_o  (inv_kind),
        .inv_lo_o    (inv_lo),
        .inv_hi_o    (inv_hi),
        .inv_ack_i   (inv_ack)
    );
endmodule

// File: tb/inv_queue_engine_tb.sv
`timescale 1ns/1ps
module inv_queue_engine_tb;
    localparam int          DEPTH = 8;
    localparam logic [63:0] BASE  = 64'h1000;
    localparam logic [7:0]  A_CAP = 8'h10, A_CMD = 8'h18, A_GST = 8'h1C;
    localparam logic [7:0]  A_HEAD = 8'h80, A_TAIL = 8'h88, A_BASE = 8'h90, A_CPL = 8'h98;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [63:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr, mem_rdata;
    logic [31:0] mem_wdata;
    logic        inv_req, inv_ack;
    logic [3:0]  inv_kind;
    logic [63:0] inv_lo, inv_hi;

    inv_queue_engine #(.RING_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .inv_req(inv_req),
        .inv_kind(inv_kind), .inv_lo(inv_lo), .inv_hi(inv_hi), .inv_ack(inv_ack)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [63:0] ring [0:2*DEPTH-1];
    logic [63:0] rd_log [0:255];  logic [63:0] exp_rd [0:255];
    logic [63:0] wa_log [0:63];   logic [63:0] exp_wa [0:63];
    logic [31:0] wd_log [0:63];   logic [31:0] exp_wd [0:63];
    logic [3:0]  ik_log [0:63];   logic [3:0]  exp_ik [0:63];
    logic [63:0] il_log [0:63];   logic [63:0] exp_il [0:63];
    logic [63:0] ih_log [0:63];   logic [63:0] exp_ih [0:63];
    int rd_n = 0, exp_rd_n = 0, wr_n = 0, exp_wr_n = 0, inv_n = 0, exp_inv_n = 0;
    int inv_delay = 0;
    int tidx = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rw(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Memory responder: one-cycle ack pulses, logs every access
    initial begin
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    if (wr_n < 64) begin wa_log[wr_n] = mem_addr; wd_log[wr_n] = mem_wdata; end
                    wr_n++;
                end else begin
                    if (rd_n < 256) rd_log[rd_n] = mem_addr;
                    rd_n++;
                    if (mem_addr >= BASE && mem_addr < BASE + 64'(DEPTH*16))
                        mem_rdata = ring[(mem_addr - BASE) >> 3];
                    else
                        mem_rdata = 64'hDEAD_DEAD_DEAD_DEAD;
                end
            end
        end
    end

    // Invalidation responder with programmable delay
    initial begin
        int cnt;
        inv_ack = 1'b0; cnt = 0;
        forever begin
            @(negedge clk);
            if (inv_ack) begin inv_ack = 1'b0; cnt = 0; end
            else if (inv_req) begin
                if (cnt >= inv_delay) begin
                    inv_ack = 1'b1;
                    if (inv_n < 64) begin
                        ik_log[inv_n] = inv_kind; il_log[inv_n] = inv_lo; ih_log[inv_n] = inv_hi;
                    end
                    inv_n++;
                end else cnt++;
            end
        end
    end

    task automatic put_desc(input logic [63:0] lo, input logic [63:0] hi, input bit e_inv, input bit e_wr);
        ring[2*tidx] = lo; ring[2*tidx+1] = hi;
        exp_rd[exp_rd_n] = BASE + 64'(tidx*16); exp_rd[exp_rd_n+1] = BASE + 64'(tidx*16 + 8);
        exp_rd_n += 2;
        if (e_inv) begin
            exp_ik[exp_inv_n] = lo[3:0]; exp_il[exp_inv_n] = lo; exp_ih[exp_inv_n] = hi;
            exp_inv_n++;
        end
        if (e_wr) begin
            exp_wa[exp_wr_n] = hi; exp_wd[exp_wr_n] = lo[63:32];
            exp_wr_n++;
        end
        tidx = (tidx + 1) % DEPTH;
    endtask

    // Build a descriptor: bits 3:0 type, bit 5 write flag, 31:8 tag, 63:32 status
    task automatic make_desc(input int k, input int t, input bit wbit);
        logic [63:0] lo, hi;
        lo = {32'hC0DE_0000 + 32'(k), 24'(k), 2'b00, wbit, 1'b0, 4'(t)};
        hi = (t == 5) ? 64'h2000 + 64'(k*8) : {32'hFEED_0000, 32'(k)};
        put_desc(lo, hi, (t >= 1 && t <= 4), (t == 5 && wbit));
    endtask

    task automatic ring_bell();
        rw(A_TAIL, 64'(tidx*16));
    endtask

    task automatic drain(input string req);
        logic [63:0] v;
        bit ok = 0;
        for (int i = 0; i < 3000 && !ok; i++) begin
            rd(A_HEAD, v);
            if (v == 64'(tidx*16)) ok = 1;
        end
        chk(ok, req, v, 64'(tidx*16));
    endtask

    task automatic compare_logs(input string tag);
        bit ok;
        ok = (rd_n == exp_rd_n);
        for (int i = 0; i < exp_rd_n && ok; i++) if (rd_log[i] != exp_rd[i]) ok = 0;
        chk(ok, {"R5 fetch addresses ", tag}, 64'(rd_n), 64'(exp_rd_n));
        ok = (inv_n == exp_inv_n);
        for (int i = 0; i < exp_inv_n && ok; i++)
            if (ik_log[i] != exp_ik[i] || il_log[i] != exp_il[i] || ih_log[i] != exp_ih[i]) ok = 0;
        chk(ok, {"R6 invalidation requests ", tag}, 64'(inv_n), 64'(exp_inv_n));
        ok = (wr_n == exp_wr_n);
        for (int i = 0; i < exp_wr_n && ok; i++)
            if (wa_log[i] != exp_wa[i] || wd_log[i] != exp_wd[i]) ok = 0;
        chk(ok, {"R7/R8 status writes ", tag}, 64'(wr_n), 64'(exp_wr_n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        int k, start_rd, old;
        bit had_wait, seen;
        for (int i = 0; i < 2*DEPTH; i++) ring[i] = '0;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_HEAD, v); chk(v == 0, "R1 head", v, 0);
        rd(A_TAIL, v); chk(v == 0, "R1 tail", v, 0);
        rd(A_BASE, v); chk(v == 0, "R1 base", v, 0);
        rd(A_CPL, v);  chk(v == 0, "R1 completion status", v, 0);
        rd(A_GST, v);  chk(v == 0, "R1 global status", v, 0);
        chk(!mem_req && !inv_req, "R1 idle ports", {62'd0, mem_req, inv_req}, 0);
        // R2 capability
        rd(A_CAP, v);  chk(v == 64'h2, "R2 capability", v, 64'h2);

        // R4 tail recorded while disabled, no fetch
        rw(A_TAIL, 64'h30);
        repeat (20) @(negedge clk);
        rd(A_TAIL, v); chk(v == 64'h30, "R4 tail readback", v, 64'h30);
        chk(rd_n == 0, "R4 no fetch while disabled", 64'(rd_n), 0);

        // R3 enable
        rw(A_TAIL, 0);
        rw(A_BASE, BASE);
        rw(A_CMD, 64'h1 << 26);
        rd(A_GST, v);  chk(v == (64'h1 << 26), "R3 enabled status", v, 64'h1 << 26);

        // Sweep of all valid types over wrapping batches (R5-R8, R10, R11)
        k = 0;
        for (int r = 0; r < 8; r++) begin
            inv_delay = r % 4;
            had_wait = 0;
            for (int j = 0; j < (r % 4) + 1; j++) begin
                if ((k % 5) + 1 == 5) had_wait = 1;
                make_desc(k, (k % 5) + 1, 1'((k / 5) % 2));
                k++;
            end
            ring_bell();
            drain("R11 head reaches tail");
            compare_logs("sweep");
            rd(A_CPL, v);
            chk(v == 64'(had_wait), "R7/R8 done flag", v, 64'(had_wait));
            if (had_wait) begin
                rw(A_CPL, 64'h0);
                rd(A_CPL, v); chk(v == 1, "R10 write 0 keeps flag", v, 1);
                rw(A_CPL, 64'h1);
                rd(A_CPL, v); chk(v == 0, "R10 write 1 clears flag", v, 0);
            end
        end

        // R11 empty ring stays quiet
        start_rd = rd_n;
        repeat (30) @(negedge clk);
        chk(rd_n == start_rd, "R11 no fetch when empty", 64'(rd_n), 64'(start_rd));

        // R6 head holds while the acknowledge is delayed
        inv_delay = 40;
        old = tidx;
        make_desc(100, 2, 0);
        make_desc(101, 3, 0);
        ring_bell();
        seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (inv_req) seen = 1;
        end
        repeat (10) @(negedge clk);
        rd(A_HEAD, v); chk(v == 64'(old*16), "R6 head before ack", v, 64'(old*16));
        chk(inv_req == 1'b1, "R6 request held", 64'(inv_req), 1);
        inv_delay = 1;
        drain("R6 head after ack");
        compare_logs("held ack");

        // R9 every unused type code faults, parks, and retries after repair
        for (int c = 0; c < 16; c++) begin
            if (c >= 1 && c <= 5) continue;
            old = tidx;
            put_desc({32'hFACE_0000 | 32'(c), 28'h0, 4'(c)}, 64'h0, 0, 0);
            ring_bell();
            repeat (25) @(negedge clk);
            rd(A_CPL, v);  chk(v[1] == 1'b1, "R9 fault flag", v, 64'h2);
            rd(A_HEAD, v); chk(v == 64'(old*16), "R9 head parked", v, 64'(old*16));
            compare_logs("fault");
            ring[2*old] = {32'h0, 28'h0, 4'd5};
            exp_rd[exp_rd_n] = BASE + 64'(old*16); exp_rd[exp_rd_n+1] = BASE + 64'(old*16 + 8);
            exp_rd_n += 2;
            rw(A_CPL, 64'h2);
            drain("R9 retry after clear");
            rd(A_CPL, v);  chk(v == 1, "R9 fault cleared, retried wait done", v, 1);
            rw(A_CPL, 64'h1);
        end
        compare_logs("after faults");

        // R3 disable resets head; R4 tail still recorded
        rw(A_CMD, 0);
        rd(A_HEAD, v); chk(v == 0, "R3 head zero when disabled", v, 0);
        rd(A_GST, v);  chk(v == 0, "R3 status clear when disabled", v, 0);
        start_rd = rd_n;
        rw(A_TAIL, 64'h50);
        repeat (20) @(negedge clk);
        rd(A_TAIL, v); chk(v == 64'h50, "R4 tail readback disabled", v, 64'h50);
        chk(rd_n == start_rd, "R4 no fetch after disable", 64'(rd_n), 64'(start_rd));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule